// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block steers the driver-enable pin of an RS-485 transceiver from the activity of a UART transmitter. Nothing needs to toggle the pin in software. While automatic steering is on, the pin moves to its drive level as soon as transmit data is waiting or the shifter is busy. It returns to its listen level once both are idle. The polarity of the pin comes from the configuration byte, so the drive level and the listen level always differ.

The first port instance can add two guard windows, each forty bit-clock ticks long (four characters of ten bits). The first window sits between raising the drive level and letting the transmitter start; the block holds the transmitter back through a start-permission output. The second window sits between the end of the last character and releasing the pin. Fresh data that arrives inside the second window cancels the release and does not repeat the first window. Other port instances ignore both guard bits. When automatic steering is off, the pin simply mirrors the modem-control RTS bit.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: With configuration bit 4 clear, `rts` equals `mcrRts` combinationally and `txGo` is 1, whatever the transmit activity.
- R2: With bit 4 set, the drive level of `rts` is configuration bit 5 and the listen level is its inverse.
- R3: With bit 4 set and no pre-delay, when `txFifoNotEmpty` or `shifterBusy` rises while idle, `rts` reaches the drive level and `txGo` goes to 1 after one clock edge. `txGo` is 0 while idle.
- R4: With bits 4 and 2 set on the first port, `rts` drives one edge after activity starts. `txGo` stays 0 through 39 `bitTick` pulses and becomes 1 after the 40th.
- R5: Without a post-delay, `rts` returns to the listen level one edge after `txFifoNotEmpty` and `shifterBusy` are both 0. It stays driven while either one is 1.
- R6: With bits 4 and 3 set on the first port, `rts` stays driven through 39 `bitTick` pulses after activity ends and returns to the listen level after the 40th.
- R7: Activity during the post-delay keeps `rts` driven and sets `txGo` after one edge, with no pre-delay. The next post-delay counts a full 40 ticks afresh.
- R8: If activity returns in the same cycle as the 40th post-delay tick, activity wins and `rts` stays driven.
- R9: An instance with `IS_FIRST_PORT` = 0 ignores bits 2 and 3. It behaves as in R3 and R5.
- R10: After reset with bit 4 set, `rts` is at the listen level and `txGo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgByte | input | 8 | Configuration: bit 2 pre-delay, bit 3 post-delay, bit 4 auto enable, bit 5 drive level |
| mcrRts | input | 1 | Modem-control RTS bit, used when automatic steering is off |
| txFifoNotEmpty | input | 1 | Transmit FIFO holds data |
| shifterBusy | input | 1 | Transmit shifter is sending a character |
| bitTick | input | 1 | One-cycle pulse per bit time |
| rts | output | 1 | Transceiver direction pin |
| txGo | output | 1 | Permission for the transmitter to start a character |

## Verification
Two events can land on the same clock edge. One is the expiry of the post-delay on its fortieth tick. The other is the return of transmit activity, which cancels that release. The bench first brings the block 39 ticks into the post-delay. It then raises the tick and the FIFO-not-empty input together for one cycle and requires `rts` to stay at the drive level and `txGo` to be 1. Next, the bench lets activity end and requires a full fresh 40-tick window before `rts` releases. This shows that the cancel also restarted the count.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PRE    = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_POST   = 2'd3
  } dirState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic drive;
    logic txGo;
  } dirStrobe_t;

  localparam int CFG_PRE_BIT  = 2;
  localparam int CFG_POST_BIT = 3;
  localparam int CFG_AUTO_BIT = 4;
  localparam int CFG_POL_BIT  = 5;

endpackage

// File: rtl/rs485_dir_dp.sv
module rs485_dir_dp
  import rs485_dir_pkg::*;
#(
  parameter int DELAY_TICKS = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  dirStrobe_t strobe,
  input  logic       autoEn,
  input  logic       driveLevel,
  input  logic       mcrRts,
  output logic       delayDone,
  output logic       rts,
  output logic       txGo
);
  localparam int CNT_W = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DELAY_TICKS - 1);

  logic [CNT_W-1:0] tickCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strobe.cntClr) begin
      tickCnt <= '0;
    end else if (strobe.cntInc) begin
      tickCnt <= tickCnt + CNT_W'(1);
    end
  end

  assign delayDone = (tickCnt == CNT_LAST);

  always_comb begin
    if (autoEn) begin
      rts  = strobe.drive ? driveLevel : ~driveLevel;
      txGo = strobe.txGo;
    end else begin
      rts  = mcrRts;
      txGo = 1'b1;
    end
  end

endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
  import rs485_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       autoEn,
  input  logic       preEn,
  input  logic       postEn,
  input  logic       txFifoNotEmpty,
  input  logic       shifterBusy,
  input  logic       bitTick,
  input  logic       delayDone,
  output dirStrobe_t strobe
);
  dirState_t curState, nxtState;
  logic txActive, expire;

  assign txActive = txFifoNotEmpty | shifterBusy;
  assign expire   = bitTick & delayDone;

  always_ff @(posedge clk) begin
    if (!rstN) curState <= ST_IDLE;
    else       curState <= nxtState;
  end

  always_comb begin
    nxtState      = curState;
    strobe.cntClr = 1'b0;
    strobe.cntInc = 1'b0;
    unique case (curState)
      ST_IDLE: begin
        if (txActive) begin
          strobe.cntClr = 1'b1;
          nxtState = preEn ? ST_PRE : ST_ACTIVE;
        end
      end
      ST_PRE: begin
        strobe.cntInc = bitTick;
        if (expire) nxtState = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (!txActive) begin
          strobe.cntClr = 1'b1;
          nxtState = postEn ? ST_POST : ST_IDLE;
        end
      end
      ST_POST: begin
        if (txActive) begin
          nxtState = ST_ACTIVE;
        end else begin
          strobe.cntInc = bitTick;
          if (expire) nxtState = ST_IDLE;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
    if (!autoEn) nxtState = ST_IDLE;
  end

  assign strobe.drive = (curState != ST_IDLE);
  assign strobe.txGo  = (curState == ST_ACTIVE) || (curState == ST_POST);

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
#(
  parameter int IS_FIRST_PORT = 1,
  parameter int BITS_PER_CHAR = 10,
  parameter int GUARD_CHARS   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] cfgByte,
  input  logic       mcrRts,
  input  logic       txFifoNotEmpty,
  input  logic       shifterBusy,
  input  logic       bitTick,
  output logic       rts,
  output logic       txGo
);
  localparam int DELAY_TICKS = BITS_PER_CHAR * GUARD_CHARS;

  dirStrobe_t strobe;
  logic delayDone, preEn, postEn, autoEn;

  assign autoEn = cfgByte[CFG_AUTO_BIT];

  generate
    if (IS_FIRST_PORT != 0) begin : g_guard
      assign preEn  = cfgByte[CFG_PRE_BIT];
      assign postEn = cfgByte[CFG_POST_BIT];
    end else begin : g_noGuard
      assign preEn  = 1'b0;
      assign postEn = 1'b0;
    end
  endgenerate

  rs485_dir_fsm u_fsm (
    .clk            (clk),
    .rstN           (rstN),
    .autoEn         (autoEn),
    .preEn          (preEn),
    .postEn         (postEn),
    .txFifoNotEmpty (txFifoNotEmpty),
    .shifterBusy    (shifterBusy),
    .bitTick        (bitTick),
    .delayDone      (delayDone),
    .strobe         (strobe)
  );

  rs485_dir_dp #(.DELAY_TICKS(DELAY_TICKS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .autoEn     (autoEn),
    .driveLevel (cfgByte[CFG_POL_BIT]),
    .mcrRts     (mcrRts),
    .delayDone  (delayDone),
    .rts        (rts),
    .txGo       (txGo)
  );

endmodule

// File: rtl/rs485_dir_chk.sv
module rs485_dir_chk #(
  parameter int IS_FIRST_PORT = 1
) (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] cfgByte,
  input logic       mcrRts,
  input logic       txFifoNotEmpty,
  input logic       shifterBusy,
  input logic       rts,
  input logic       txGo
);
  logic busyAny;
  assign busyAny = txFifoNotEmpty | shifterBusy;

  AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    !cfgByte[4] |-> (rts == mcrRts) && txGo); // R1

  AST_GO_ONLY_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    (cfgByte[4] && txGo) |-> (rts == cfgByte[5])); // R3

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cfgByte[4] && busyAny) ##1 $stable(cfgByte) |-> (rts == cfgByte[5])); // R5

  AST_NO_GUARD_OTHER: assert property (@(posedge clk) disable iff (!rstN)
    ((IS_FIRST_PORT == 0) && cfgByte[4] && !busyAny) ##1 ($stable(cfgByte) && !busyAny)
      |-> (rts == !cfgByte[5])); // R9

endmodule

bind rs485_dir_ctrl rs485_dir_chk #(.IS_FIRST_PORT(IS_FIRST_PORT)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .cfgByte        (cfgByte),
  .mcrRts         (mcrRts),
  .txFifoNotEmpty (txFifoNotEmpty),
  .shifterBusy    (shifterBusy),
  .rts            (rts),
  .txGo           (txGo)
);

// File: tb/rs485_dir_ctrl_test.sv
`timescale 1ns/1ps
module rs485_dir_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] cfgByte = 8'h10;
  logic mcrRts = 1'b0;
  logic fifoNe = 1'b0;
  logic busy = 1'b0;
  logic bitTick = 1'b0;
  logic rts, txGo, rtsB, txGoB;
  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  rs485_dir_ctrl #(.IS_FIRST_PORT(1)) uut (
    .clk(clk), .rstN(rstN), .cfgByte(cfgByte), .mcrRts(mcrRts),
    .txFifoNotEmpty(fifoNe), .shifterBusy(busy), .bitTick(bitTick),
    .rts(rts), .txGo(txGo));

  rs485_dir_ctrl #(.IS_FIRST_PORT(0)) uutOther (
    .clk(clk), .rstN(rstN), .cfgByte(cfgByte), .mcrRts(mcrRts),
    .txFifoNotEmpty(fifoNe), .shifterBusy(busy), .bitTick(bitTick),
    .rts(rtsB), .txGo(txGoB));

  task automatic check(input string req, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      bitTick = 1'b1; step();
      bitTick = 1'b0; step();
    end
  endtask

  task automatic tReset();
    check("R10 rts listen", rts, ~cfgByte[5]);
    check("R10 txGo low", txGo, 1'b0);
  endtask

  task automatic tManual();
    cfgByte = 8'h2C; mcrRts = 1'b0; fifoNe = 1'b1; #1;
    check("R1 rts follows 0", rts, 1'b0);
    check("R1 txGo high", txGo, 1'b1);
    step(); mcrRts = 1'b1; #1;
    check("R1 rts follows 1", rts, 1'b1);
    fifoNe = 1'b0; step(); step();
  endtask

  task automatic tPolarity();
    cfgByte = 8'h30; mcrRts = 1'b0; step();
    check("R2 listen low", rts, 1'b0);
    fifoNe = 1'b1; #1;
    check("R3 txGo low idle", txGo, 1'b0);
    step();
    check("R3 R2 drive high", rts, 1'b1);
    check("R3 txGo", txGo, 1'b1);
    fifoNe = 1'b0; busy = 1'b1; step();
    check("R5 shifter holds", rts, 1'b1);
    busy = 1'b0; step();
    check("R5 release", rts, 1'b0);
    cfgByte = 8'h10; step();
    check("R2 listen high", rts, 1'b1);
    fifoNe = 1'b1; step();
    check("R2 drive low", rts, 1'b0);
    fifoNe = 1'b0; step();
    check("R2 back high", rts, 1'b1);
  endtask

  task automatic tPre();
    cfgByte = 8'h34; step();
    fifoNe = 1'b1; step();
    check("R4 rts driven", rts, 1'b1);
    check("R4 txGo held", txGo, 1'b0);
    check("R9 other txGo", txGoB, 1'b1);
    pulses(39);
    check("R4 txGo after 39", txGo, 1'b0);
    pulses(1);
    check("R4 txGo after 40", txGo, 1'b1);
    fifoNe = 1'b0; step();
    check("R5 release no post", rts, 1'b0);
  endtask

  task automatic tPost();
    cfgByte = 8'h38; fifoNe = 1'b1; step();
    check("R9 no pre on port0", txGo, 1'b1);
    fifoNe = 1'b0; step();
    check("R6 held", rts, 1'b1);
    check("R9 other released", rtsB, 1'b0);
    pulses(39);
    check("R6 held after 39", rts, 1'b1);
    pulses(1);
    check("R6 released after 40", rts, 1'b0);
  endtask

  task automatic tCancel();
    cfgByte = 8'h3C; fifoNe = 1'b1; step();
    pulses(40);
    fifoNe = 1'b0; step();
    pulses(10);
    fifoNe = 1'b1; step();
    check("R7 rts kept", rts, 1'b1);
    check("R7 no pre repeat", txGo, 1'b1);
    fifoNe = 1'b0; step();
    pulses(39);
    check("R7 count restarted", rts, 1'b1);
    pulses(1);
    check("R7 released", rts, 1'b0);
  endtask

  task automatic tSameCycle();
    cfgByte = 8'h38; fifoNe = 1'b1; step();
    fifoNe = 1'b0; step();
    pulses(39);
    bitTick = 1'b1; fifoNe = 1'b1; step();
    bitTick = 1'b0;
    check("R8 activity wins rts", rts, 1'b1);
    check("R8 activity wins txGo", txGo, 1'b1);
    fifoNe = 1'b0; step();
    pulses(39);
    check("R8 fresh window", rts, 1'b1);
    pulses(1);
    check("R8 final release", rts, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    step(); step();
    tReset();
    rstN = 1'b1; step();
    tReset();
    tManual();
    tPolarity();
    tPre();
    tPost();
    tCancel();
    tSameCycle();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule